// File: doc/BRIEF.md
# Root Port Error Status and Interrupt Unit

This block sits in a root port and collects error messages that have already been routed to it. Each message carries a two-bit severity and a 16-bit requester identifier. The block keeps a root error status register that records whether correctable and uncorrectable errors have arrived. It records whether more than one of each kind has arrived and whether the first uncorrectable error was fatal. It latches the identifier of the first correctable and the first uncorrectable requester.

Software reaches the block through a small word-addressed register port. Address 0 is the root command register, which holds three enables: bit 0 for correctable, bit 1 for non-fatal and bit 2 for fatal. Address 1 is the root status register. Address 2 holds the two source fields: the correctable source in bits 15:0 and the uncorrectable source in bits 31:16. Address 3 reads as zero. An interrupt is raised only when the enabled condition becomes newly true. With message-signalled interrupts enabled this is a one-cycle request pulse. With them disabled, a level INTx line follows the enabled condition.

Top module: `root_err_irq`

## Requirements
- R1: A correctable message (severity code 0) sets status bit 0. If bit 0 was already set, it sets bit 1 and leaves the correctable source (address 2, bits 15:0) unchanged. Otherwise it captures the message source there.
- R2: A non-fatal (code 1) or fatal (code 2) message sets status bit 2. If bit 2 was already set, it sets bit 3 and leaves the uncorrectable source (address 2, bits 31:16) unchanged. Otherwise it captures the message source there.
- R3: A fatal message sets status bit 6. It also sets bit 4, but only if bit 2 was clear before the message. A non-fatal message sets status bit 5.
- R4: A message with severity code 3 changes no status, no source field and raises no interrupt.
- R5: With MSI enabled, a message produces a one-cycle `msi_req_o` pulse in the cycle after it is accepted. This happens only when the command enable for its severity is set and no enabled condition was true before the message. The enabled condition is (command AND mapped status), where status bits 0, 5 and 6 map onto command bits 0, 1 and 2.
- R6: With MSI enabled, a command write produces the pulse only if the enabled condition goes from zero to nonzero.
- R7: With MSI disabled, `intx_o` equals the OR of the enabled condition, and no MSI pulse is produced. With MSI enabled, `intx_o` is low.
- R8: Writing ones to status bits 6:0 clears them. Status bits 31:27 hold the interrupt message number. Software writes leave that field unchanged; it loads from `num_i` when `num_we_i` is high.
- R9: After reset, command, status and both source fields read zero. Only command bits 2:0 are writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| msg_valid_i | input | 1 | Error message present this cycle |
| msg_sev_i | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 ignored |
| msg_src_i | input | 16 | Requester identifier of the message |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| num_we_i | input | 1 | Load interrupt message number |
| num_i | input | 5 | Interrupt message number from device logic |
| msi_en_i | input | 1 | Message-signalled interrupts enabled |
| msi_req_o | output | 1 | One-cycle MSI request |
| intx_o | output | 1 | Level legacy interrupt |

## Verification
Directed sequences first repeat the same severity, to separate first-error capture from the multiple-error flags. They then send a fatal message after a non-fatal one and a fatal message on a clean status, which tells the first-fatal rule apart from plain fatal recording. Command writes are made with the enabled condition already true and with it false, which distinguishes edge from level signalling. Random runs interleave messages of all four codes, command writes, status clears, number loads and MSI mode changes. They compare every register, the pulse and the INTx level against a bench model after each step.

// File: rtl/root_err_pkg.sv
package root_err_pkg;
  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_RSVD     = 2'd3
  } sev_e;

  localparam int unsigned STAT_W      = 7;
  localparam int unsigned CMD_W       = 3;
  localparam int unsigned B_COR       = 0;
  localparam int unsigned B_MULTI_COR = 1;
  localparam int unsigned B_UNC       = 2;
  localparam int unsigned B_MULTI_UNC = 3;
  localparam int unsigned B_FIRST_FAT = 4;
  localparam int unsigned B_NONFATAL  = 5;
  localparam int unsigned B_FATAL     = 6;

  function automatic logic [CMD_W-1:0] stat_to_cmd(input logic [STAT_W-1:0] s);
    return {s[B_FATAL], s[B_NONFATAL], s[B_COR]};
  endfunction

  function automatic logic [CMD_W-1:0] sev_to_cmd(input logic [1:0] sev);
    logic [CMD_W-1:0] r;
    r = '0;
    if (sev != SEV_RSVD) r[sev] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/root_err_status.sv
module root_err_status
  import root_err_pkg::*;
#(
  parameter int unsigned SRC_W = 16,
  parameter int unsigned NUM_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic [1:0]        msg_sev_i,
  input  logic [SRC_W-1:0]  msg_src_i,
  input  logic              clr_en_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  input  logic              num_we_i,
  input  logic [NUM_W-1:0]  num_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [SRC_W-1:0]  cor_src_o,
  output logic [SRC_W-1:0]  unc_src_o,
  output logic [NUM_W-1:0]  num_o
);
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [SRC_W-1:0]  cor_q, cor_d, unc_q, unc_d;
  logic [NUM_W-1:0]  num_q;

  always_comb begin
    stat_d = stat_q;
    cor_d  = cor_q;
    unc_d  = unc_q;
    if (clr_en_i) stat_d = stat_d & ~clr_mask_i;
    if (msg_valid_i) begin
      unique case (sev_e'(msg_sev_i))
        SEV_COR: begin
          if (stat_q[B_COR]) stat_d[B_MULTI_COR] = 1'b1;
          else               cor_d = msg_src_i;
          stat_d[B_COR] = 1'b1;
        end
        SEV_NONFATAL, SEV_FATAL: begin
          if (stat_q[B_UNC]) stat_d[B_MULTI_UNC] = 1'b1;
          else               unc_d = msg_src_i;
          stat_d[B_UNC] = 1'b1;
          if (msg_sev_i == SEV_FATAL) begin
            if (!stat_q[B_UNC]) stat_d[B_FIRST_FAT] = 1'b1;
            stat_d[B_FATAL] = 1'b1;
          end else begin
            stat_d[B_NONFATAL] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      cor_q  <= '0;
      unc_q  <= '0;
      num_q  <= '0;
    end else begin
      stat_q <= stat_d;
      cor_q  <= cor_d;
      unc_q  <= unc_d;
      if (num_we_i) num_q <= num_i;
    end
  end

  assign stat_o    = stat_q;
  assign cor_src_o = cor_q;
  assign unc_src_o = unc_q;
  assign num_o     = num_q;
endmodule

// File: rtl/root_err_irq_gen.sv
module root_err_irq_gen
  import root_err_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msi_en_i,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             msg_valid_i,
  input  logic [1:0]       msg_sev_i,
  input  logic [CMD_W-1:0] stat_map_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             msi_req_o,
  output logic             intx_o
);
  logic [CMD_W-1:0] cmd_q;
  logic             msi_q, msi_d, was_on, msg_fire, wr_fire;

  assign was_on   = |(cmd_q & stat_map_i);
  assign msg_fire = msg_valid_i && |(cmd_q & sev_to_cmd(msg_sev_i)) && !was_on;
  // edge only: command change that turns the enabled condition on
  assign wr_fire  = cmd_wr_i && !was_on && |(cmd_wdata_i & stat_map_i);
  assign msi_d    = msi_en_i && (msg_fire || wr_fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      msi_q <= 1'b0;
    end else begin
      if (cmd_wr_i) cmd_q <= cmd_wdata_i;
      msi_q <= msi_d;
    end
  end

  assign cmd_o     = cmd_q;
  assign msi_req_o = msi_q;
  assign intx_o    = !msi_en_i && was_on;
endmodule

// File: rtl/root_err_irq.sv
module root_err_irq
  import root_err_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned SRC_W  = 16,
  parameter int unsigned NUM_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic [1:0]        msg_sev_i,
  input  logic [SRC_W-1:0]  msg_src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              num_we_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic              msi_en_i,
  output logic              msi_req_o,
  output logic              intx_o
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(2);
  localparam int unsigned NUM_LSB = DATA_W - NUM_W;

  logic [STAT_W-1:0] status_q;
  logic [SRC_W-1:0]  cor_src_q, unc_src_q;
  logic [NUM_W-1:0]  num_q;
  logic [CMD_W-1:0]  cmd_q;

  root_err_status #(.SRC_W(SRC_W), .NUM_W(NUM_W)) i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msg_valid_i(msg_valid_i),
    .msg_sev_i  (msg_sev_i),
    .msg_src_i  (msg_src_i),
    .clr_en_i   (wr_en_i && addr_i == A_STAT),
    .clr_mask_i (wdata_i[STAT_W-1:0]),
    .num_we_i   (num_we_i),
    .num_i      (num_i),
    .stat_o     (status_q),
    .cor_src_o  (cor_src_q),
    .unc_src_o  (unc_src_q),
    .num_o      (num_q)
  );

  root_err_irq_gen i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msi_en_i   (msi_en_i),
    .cmd_wr_i   (wr_en_i && addr_i == A_CMD),
    .cmd_wdata_i(wdata_i[CMD_W-1:0]),
    .msg_valid_i(msg_valid_i),
    .msg_sev_i  (msg_sev_i),
    .stat_map_i (stat_to_cmd(status_q)),
    .cmd_o      (cmd_q),
    .msi_req_o  (msi_req_o),
    .intx_o     (intx_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CMD:  rdata_o[CMD_W-1:0] = cmd_q;
      A_STAT: begin
        rdata_o[STAT_W-1:0]      = status_q;
        rdata_o[NUM_LSB +: NUM_W] = num_q;
      end
      A_SRC:  rdata_o[2*SRC_W-1:0] = {unc_src_q, cor_src_q};
      default: ;
    endcase
  end
endmodule

// File: rtl/root_err_irq_chk.sv
module root_err_irq_chk
  import root_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned SRC_W  = 16,
  parameter int unsigned NUM_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              msg_valid_i,
  input logic [1:0]        msg_sev_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              num_we_i,
  input logic              msi_en_i,
  input logic              msi_req_o,
  input logic [STAT_W-1:0] stat_i,
  input logic [SRC_W-1:0]  cor_src_i,
  input logic [SRC_W-1:0]  unc_src_i,
  input logic [NUM_W-1:0]  num_q_i
);
  logic cor_msg, unc_msg;
  assign cor_msg = msg_valid_i && msg_sev_i == SEV_COR;
  assign unc_msg = msg_valid_i && (msg_sev_i == SEV_NONFATAL || msg_sev_i == SEV_FATAL);

  AST_COR_SRC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cor_msg && stat_i[B_COR] |=> $stable(cor_src_i) && stat_i[B_MULTI_COR]); // R1
  AST_UNC_SRC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unc_msg && stat_i[B_UNC] |=> $stable(unc_src_i) && stat_i[B_MULTI_UNC]); // R2
  AST_NO_LATE_FIRST_FATAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unc_msg && stat_i[B_UNC] && !stat_i[B_FIRST_FAT] |=> !stat_i[B_FIRST_FAT]); // R3
  AST_RSVD_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && msg_sev_i == SEV_RSVD && !wr_en_i |=> $stable(stat_i) && $stable(cor_src_i) && $stable(unc_src_i)); // R4
  AST_MSI_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_req_o |=> !msi_req_o); // R5
  AST_MSI_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_req_o |-> $past(msi_en_i)); // R7
  AST_NUM_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !num_we_i |=> $stable(num_q_i)); // R8
endmodule

bind root_err_irq root_err_irq_chk #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .NUM_W(NUM_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .msg_valid_i(msg_valid_i),
  .msg_sev_i  (msg_sev_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .num_we_i   (num_we_i),
  .msi_en_i   (msi_en_i),
  .msi_req_o  (msi_req_o),
  .stat_i     (status_q),
  .cor_src_i  (cor_src_q),
  .unc_src_i  (unc_src_q),
  .num_q_i    (num_q)
);

// File: tb/test_root_err_irq.sv
module test_root_err_irq;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        msg_valid = 1'b0, wr_en = 1'b0, num_we = 1'b0, msi_en = 1'b1;
  logic [1:0]  msg_sev = '0;
  logic [15:0] msg_src = '0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [4:0]  num = '0;
  logic        msi_req, intx;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // bench model
  logic [2:0]  m_cmd = '0;
  logic [6:0]  m_st = '0;
  logic [15:0] m_cor = '0, m_unc = '0;
  logic [4:0]  m_num = '0;
  logic        m_msi = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  root_err_irq i_root_err_irq (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(msg_valid), .msg_sev_i(msg_sev),
    .msg_src_i(msg_src), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .num_we_i(num_we), .num_i(num), .msi_en_i(msi_en),
    .msi_req_o(msi_req), .intx_o(intx)
  );

  function automatic logic [2:0] map_st(input logic [6:0] s);
    return {s[6], s[5], s[0]};
  endfunction

  function automatic logic [2:0] sev_bit(input logic [1:0] v);
    return (v == 2'd3) ? 3'b000 : (3'b001 << v);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk_all(input string tag);
    logic [31:0] d;
    chk({tag, " msi"}, 32'(msi_req), 32'(m_msi));
    chk({tag, " intx"}, 32'(intx), 32'(!msi_en && |(m_cmd & map_st(m_st))));
    rd(2'd0, d); chk({tag, " cmd"}, d, {29'd0, m_cmd});
    rd(2'd1, d); chk({tag, " status"}, d, {m_num, 20'd0, m_st});
    rd(2'd2, d); chk({tag, " src"}, d, {m_unc, m_cor});
    rd(2'd3, d); chk({tag, " spare"}, d, 32'd0);
  endtask

  // all ops start and end just after a negedge
  task automatic send(input logic [1:0] sev, input logic [15:0] src);
    m_msi = msi_en && |(m_cmd & sev_bit(sev)) && !(|(m_cmd & map_st(m_st)));
    if (sev == 2'd0) begin
      if (m_st[0]) m_st[1] = 1'b1; else m_cor = src;
      m_st[0] = 1'b1;
    end else if (sev != 2'd3) begin
      if (m_st[2]) m_st[3] = 1'b1; else m_unc = src;
      if (sev == 2'd2) begin
        if (!m_st[2]) m_st[4] = 1'b1;
        m_st[6] = 1'b1;
      end else m_st[5] = 1'b1;
      m_st[2] = 1'b1;
    end
    msg_valid = 1'b1; msg_sev = sev; msg_src = src;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    m_msi = 1'b0;
    if (a == 2'd0) begin
      m_msi = msi_en && !(|(m_cmd & map_st(m_st))) && |(d[2:0] & map_st(m_st));
      m_cmd = d[2:0];
    end else if (a == 2'd1) m_st = m_st & ~d[6:0];
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_num(input logic [4:0] n);
    m_msi = 1'b0; m_num = n;
    num_we = 1'b1; num = n;
    @(negedge clk);
    num_we = 1'b0;
  endtask

  task automatic idle();
    m_msi = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R9 reset");

    wr(2'd0, 32'hFFFF_FFFF); chk_all("R9 cmd write mask");
    wr(2'd0, 32'd1);         chk_all("R9 cmd write");
    send(2'd0, 16'h1111);    chk_all("R1 R5 first correctable");
    idle();                  chk_all("R5 pulse ends");
    send(2'd0, 16'h2222);    chk_all("R1 second correctable");
    send(2'd1, 16'hAAAA);    chk_all("R2 R3 non-fatal not enabled");
    send(2'd2, 16'hBBBB);    chk_all("R3 fatal after uncorrectable");
    send(2'd3, 16'hCCCC);    chk_all("R4 reserved code");
    wr(2'd1, 32'hFFFF_FFFF); chk_all("R8 clear all");
    load_num(5'h15);         chk_all("R8 number load");
    wr(2'd1, 32'hF800_0000); chk_all("R8 number read-only");
    send(2'd2, 16'hDDDD);    chk_all("R3 first fatal");
    wr(2'd0, 32'd4);         chk_all("R6 enable rises");
    wr(2'd0, 32'd6);         chk_all("R6 already true");
    msi_en = 1'b0; idle();   chk_all("R7 intx level");
    send(2'd0, 16'h3333);    chk_all("R7 no msi when disabled");
    wr(2'd1, 32'h40);        chk_all("R7 R8 clear fatal drops intx");
    msi_en = 1'b1; idle();   chk_all("R7 intx off in msi mode");

    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      if (op < 4) send(2'($urandom_range(0, 3)), 16'($urandom));
      else if (op < 6) wr(2'd0, $urandom);
      else if (op < 8) wr(2'd1, $urandom & 32'hFFFF_FF7F | ($urandom_range(0,1) << 7));
      else if (op == 8) load_num(5'($urandom));
      else begin
        msi_en = 1'($urandom); idle();
      end
      chk_all("R1 R2 R3 R4 R5 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule